// File: doc/BRIEF.md
# Toggle-Based Pulse Synchronizer

This block moves single-cycle event pulses from one clock domain into another unrelated clock domain. Each pulse is delivered as exactly one single-cycle pulse on the destination side. On the source side, every cycle in which the input pulse is high flips a one-bit level register. That level is the only signal that crosses the boundary. In the destination domain it passes through a chain of flip-flops, and a pulse is rebuilt wherever the synchronized level changes.

Because the event is carried as a change of level rather than as a short high period, no pulse can be lost. This holds however many destination cycles the level needs to settle through the chain. The destination clock must run at least as fast as the source clock, so that every level the source holds is seen by the destination at least once. There is no acknowledge path. The block is meant for event rates the destination can always follow.

Top module: `pulse_xing_sync`

## Requirements
- R1: In the source domain the crossing level register inverts on each source clock edge at which the input pulse is high, and holds its value on each edge at which the input pulse is low.
- R2: Every source cycle with the input pulse high produces exactly one single-cycle destination output pulse, and no output pulse appears without a matching input cycle.
- R3: An output pulse is first visible after the destination edge numbered SYNC_STAGES+1, or at most SYNC_STAGES+2, counted from the first destination edge after the source edge that captured the input pulse.
- R4: While the destination reset is high, the output pulse is low and every destination register clears to 0. While the source reset is high, the crossing level clears to 0.
- R5: Input pulses presented while the source reset is high are ignored and cause no output pulse. This holds as long as the crossing level was 0 before the reset.
- R6: The number of synchronizer stages is the parameter SYNC_STAGES, with a minimum of 2. A smaller value stops elaboration.
- R7: Input pulses on consecutive source cycles each yield their own output pulse, provided the destination clock is at least as fast as the source clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_pulse | input | 1 | Event input; each high cycle is one event |
| dst_clk | input | 1 | Destination domain clock, at least as fast as src_clk |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_pulse | output | 1 | Regenerated event, one registered cycle per source event |

## Verification
On every cycle, the assertions check how the source level responds to the input pulse (it flips or it holds) and how both resets clear the registers and silence the output. The one-to-one pairing of input events with output pulses, the latency window, the handling of back-to-back bursts and the ignoring of pulses during source reset all depend on the relation between the two clocks. Only the bench's scoreboard can show these. It does so by matching every observed output pulse against a queued source event and by checking the elapsed destination cycle count.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int unsigned PXS_MIN_STAGES = 2;
  localparam int unsigned PXS_DEF_STAGES = 2;
endpackage

// File: rtl/pxs_toggle_src.sv
module pxs_toggle_src (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic level_out
);
  always_ff @(posedge clk) begin
    if (rst) level_out <= 1'b0;
    else     level_out <= level_out ^ pulse_in;
  end

  // R1: an event inverts the crossing level
  a_r1_flip_on_event: assert property (@(posedge clk) disable iff (rst)
    pulse_in |=> (level_out != $past(level_out)));
  // R1: no event, level unchanged
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !pulse_in |=> $stable(level_out));
  // R4: source reset clears the level
  a_r4_src_clear: assert property (@(posedge clk)
    rst |=> !level_out);
endmodule

// File: rtl/pxs_sync_chain.sv
module pxs_sync_chain #(
  parameter int unsigned STAGES = pxs_pkg::PXS_DEF_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES < pxs_pkg::PXS_MIN_STAGES) begin : g_bad_depth
      $error("pxs_sync_chain: STAGES below minimum");
    end
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b0;
          else     stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[i] <= 1'b0;
          else     stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[LAST];

  // R4: destination reset clears the whole chain
  a_r4_chain_clear: assert property (@(posedge clk)
    rst |=> (stage_q == '0));
endmodule

// File: rtl/pxs_pulse_regen.sv
module pxs_pulse_regen (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic pulse_out
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_d   <= 1'b0;
      pulse_out <= 1'b0;
    end else begin
      level_d   <= level_in;
      pulse_out <= level_in ^ level_d;
    end
  end

  // R4: output silent in the cycle after destination reset
  a_r4_out_low_after_rst: assert property (@(posedge clk)
    rst |=> !pulse_out);
endmodule

// File: rtl/pulse_xing_sync.sv
module pulse_xing_sync #(
  parameter int unsigned SYNC_STAGES = pxs_pkg::PXS_DEF_STAGES
) (
  input  logic src_clk,
  input  logic src_rst,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst,
  output logic dst_pulse
);
  logic src_level;
  logic dst_level;

  pxs_toggle_src u_src (
    .clk      (src_clk),
    .rst      (src_rst),
    .pulse_in (src_pulse),
    .level_out(src_level)
  );

  pxs_sync_chain #(.STAGES(SYNC_STAGES)) u_chain (
    .clk     (dst_clk),
    .rst     (dst_rst),
    .async_in(src_level),
    .sync_out(dst_level)
  );

  pxs_pulse_regen u_regen (
    .clk      (dst_clk),
    .rst      (dst_rst),
    .level_in (dst_level),
    .pulse_out(dst_pulse)
  );
endmodule

// File: tb/pulse_xing_sync_test.sv
`timescale 1ns/100ps
module pulse_xing_sync_test;
  localparam int unsigned STG = 3;

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst = 1'b1;
  logic dst_rst = 1'b1;
  logic src_pulse = 1'b0;
  logic dst_pulse;

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int seen = 0;
  int dst_cyc = 0;
  int exp_q[$];
  bit done = 0;

  always #4   dst_clk = ~dst_clk;   // 125 MHz
  always #6.5 src_clk = ~src_clk;   // slower source

  pulse_xing_sync #(.SYNC_STAGES(STG)) uut (
    .src_clk(src_clk), .src_rst(src_rst), .src_pulse(src_pulse),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_pulse(dst_pulse)
  );

  always @(posedge dst_clk) dst_cyc++;

  // Expected items: the destination cycle count when an event is captured
  always @(posedge src_clk) begin
    if (!src_rst && src_pulse) begin
      exp_q.push_back(dst_cyc);
      sent++;
    end
  end

  // Monitor: pop and compare every output pulse (R2, R3, R6)
  always @(negedge dst_clk) begin
    if (!dst_rst && dst_pulse) begin
      seen++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unmatched output pulse, actual=1 expected=0 at cycle %0d", dst_cyc);
      end else begin
        int lat;
        lat = dst_cyc - exp_q.pop_front();
        if (lat < STG + 1 || lat > STG + 2) begin
          errors++;
          $display("FAIL R3/R6: latency actual=%0d expected=%0d..%0d", lat, STG + 1, STG + 2);
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic burst(input int n);
    @(negedge src_clk) src_pulse = 1'b1;
    repeat (n) @(negedge src_clk);
    src_pulse = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge src_clk);
  endtask

  initial begin
    // R4: output low throughout reset
    for (int i = 0; i < 5; i++) begin
      @(negedge dst_clk);
      check("R4", dst_pulse, 0);
    end
    @(negedge dst_clk) dst_rst = 1'b0;
    @(negedge src_clk) src_rst = 1'b0;
    gap(4);
    check("R4", seen, 0);

    // R1/R2/R3: isolated single events
    for (int i = 0; i < 4; i++) begin
      burst(1);
      gap(8);
    end
    check("R2", seen, 4);

    // R7: back-to-back events on consecutive source cycles
    burst(4);
    gap(10);
    check("R7", seen, 8);

    // R5: events during source reset are ignored (level is 0 here)
    @(negedge src_clk) src_rst = 1'b1;
    burst(3);
    @(negedge src_clk) src_rst = 1'b0;
    gap(12);
    check("R5", seen, 8);

    // R1: operation resumes after source reset
    burst(1);
    gap(10);
    check("R1", seen, 9);

    // R7: long burst
    burst(6);
    gap(12);
    check("R7", seen, 15);

    // R2: everything matched, nothing left over
    check("R2", exp_q.size(), 0);
    check("R2", seen, sent);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge dst_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule